// File: doc/BRIEF.md
# Two-Level Table Entry Locator

The locator turns an identifier into the 64-bit table entry that belongs to it. It serves two tables, a device table and a collection table. Each table has its own base address, its own layout choice (flat or two-level) and its own page-size code. A lookup request names the table and the identifier. The locator then reads memory through a request/response port and returns the entry together with a hit flag.

In flat layout the entry sits directly in one array starting at the table base, so a single read is enough. In two-level layout the identifier is split at a point set by the page size:

- The upper part selects an 8-byte first-level descriptor.
- That descriptor must carry its valid mark. If it does, it supplies the base of a second-level page.
- The lower part of the identifier selects the entry inside that page.

Only one lookup is in flight at a time. The request side and the result side are both valid/ready streams:

- `req_ready` is high only while the block is idle. A request is accepted on a cycle where `req_valid` and `req_ready` are both high.
- A result is offered with `res_valid` and held unchanged until `res_ready` is seen. No new request is taken until then.
- On the memory side, `mem_req_valid` and `mem_req_addr` stay stable until `mem_req_ready` is seen.
- The memory returns exactly one `mem_rsp_valid` beat per accepted read. That beat cannot be back-pressured.

Top module: `tel_locator`

## Requirements
- R1: After reset, `req_ready` is 1, and `mem_req_valid` and `res_valid` are 0.
- R2: With a flat table, the lookup issues exactly one read, at address base + id × entry size. Device entries are 8 bytes and collection entries are 16 bytes (`req_table` 0 = device, 1 = collection).
- R3: With a two-level table, the first read goes to base + (id / (page / 8)) × 8. Page-size code 0 means a 4096-byte page, code 1 a 16384-byte page and code 2 a 65536-byte page.
- R4: A first-level descriptor word is usable only when its bit 63 is 1. Otherwise no second read is made, and the result has `res_hit` 0 and `res_entry` 0.
- R5: When the descriptor is usable, the second read goes to ((desc >> code) masked to its low 51 − code bits) + (id mod (page / entry size)) × entry size.
- R6: Memory words are little-endian 64-bit values, so bit 0 is the least significant bit of the lowest-addressed byte. `res_entry` is the word read, and `res_hit` equals its bit 0.
- R7: Page-size code 3 on a two-level table is reserved. The lookup completes with `res_hit` 0, `res_entry` 0 and no memory read.
- R8: Once a request is accepted, `req_ready` stays 0 until the result has been taken.
- R9: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the read request and its address do not change in the next cycle.
- R10: While `res_valid` is 1 and `res_ready` is 0, `res_valid`, `res_entry` and `res_hit` do not change in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request offered |
| req_ready | output | 1 | Block idle; accepts a request |
| req_id | input | ID_W | Identifier to locate |
| req_table | input | 1 | 0 = device table, 1 = collection table |
| dev_base | input | ADDR_W | Device table base address |
| dev_indirect | input | 1 | Device table is two-level |
| dev_page_code | input | 2 | Device table page-size code |
| col_base | input | ADDR_W | Collection table base address |
| col_indirect | input | 1 | Collection table is two-level |
| col_page_code | input | 2 | Collection table page-size code |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | ADDR_W | Byte address of the 64-bit read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Read data word |
| res_valid | output | 1 | Result offered |
| res_ready | input | 1 | Result taken |
| res_entry | output | 64 | Entry word, 0 when no entry was read |
| res_hit | output | 1 | Entry present and valid |

## Verification
The assertions rely on the following assumptions about the environment:

- The memory sends one response, and only one, for each accepted read.
- That response arrives only while the block waits for it.
- The table configuration pins are sampled only at request acceptance.

The bench's memory model keeps to these rules. It answers exactly one cycle after each handshake and never answers unprompted. It also stalls `mem_req_ready` on a fixed rhythm, so that the address-hold and result-hold properties see real back-pressure. The bench changes configuration only between lookups.

// File: rtl/tel_pkg.sv
package tel_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_L1_REQ   = 3'd1,
    ST_L1_WAIT  = 3'd2,
    ST_ENT_REQ  = 3'd3,
    ST_ENT_WAIT = 3'd4,
    ST_DONE     = 3'd5
  } walk_state_t;

  localparam logic [1:0] PG_CODE_RSVD = 2'd3;
  localparam int unsigned DESC_LOG2   = 3;   // first-level descriptor is 8 bytes
  localparam int unsigned DESC_VALID  = 63;  // descriptor valid bit
  localparam int unsigned L2_MASK_TOP = 51;  // level-2 base width before code adjust

  // log2 of page bytes for a page-size code (codes 0..2 -> 12, 14, 16)
  function automatic int unsigned page_log2(input logic [1:0] code);
    return 32'd12 + 32'd2 * 32'(code);
  endfunction

endpackage

// File: rtl/tel_addr_gen.sv
module tel_addr_gen
  import tel_pkg::*;
#(
  parameter int ADDR_W = 52,
  parameter int ID_W   = 20
) (
  input  logic [ID_W-1:0]   id,
  input  logic [ADDR_W-1:0] base,
  input  logic [1:0]        pg_code,
  input  logic [2:0]        ent_log2,
  input  logic [63:0]       l1_desc,
  output logic [ADDR_W-1:0] flat_addr,
  output logic [ADDR_W-1:0] l1_addr,
  output logic [ADDR_W-1:0] l2_addr
);

  logic [63:0] id_w;
  logic [63:0] l1_idx;
  logic [63:0] l2_idx_mask;
  logic [63:0] l2_base_mask;
  logic [63:0] l2_base;
  int unsigned plog;

  always_comb begin
    id_w         = 64'(id);
    plog         = page_log2(pg_code);
    l1_idx       = id_w >> (plog - DESC_LOG2);
    l2_idx_mask  = (64'd1 << (plog - 32'(ent_log2))) - 64'd1;
    l2_base_mask = (64'd1 << (L2_MASK_TOP - 32'(pg_code))) - 64'd1;
    l2_base      = (l1_desc >> pg_code) & l2_base_mask;
    flat_addr    = base + ADDR_W'(id_w << ent_log2);
    l1_addr      = base + ADDR_W'(l1_idx << DESC_LOG2);
    l2_addr      = ADDR_W'(l2_base + ((id_w & l2_idx_mask) << ent_log2));
  end

endmodule

// File: rtl/tel_walker.sv
module tel_walker
  import tel_pkg::*;
#(
  parameter int ADDR_W = 52,
  parameter int ID_W   = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ID_W-1:0]   req_id,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic              cfg_indirect,
  input  logic [1:0]        cfg_page_code,
  input  logic [2:0]        cfg_ent_log2,
  output logic [ID_W-1:0]   id_q,
  output logic [ADDR_W-1:0] base_q,
  output logic [1:0]        code_q,
  output logic [2:0]        elog_q,
  output logic [63:0]       desc_q,
  input  logic [ADDR_W-1:0] flat_addr,
  input  logic [ADDR_W-1:0] l1_addr,
  input  logic [ADDR_W-1:0] l2_addr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [63:0]       res_entry,
  output logic              res_hit
);

  walk_state_t st_q;
  logic        ind_q;
  logic [63:0] entry_q;
  logic        hit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      id_q    <= '0;
      base_q  <= '0;
      code_q  <= '0;
      elog_q  <= '0;
      ind_q   <= 1'b0;
      desc_q  <= '0;
      entry_q <= '0;
      hit_q   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid) begin
          id_q    <= req_id;
          base_q  <= cfg_base;
          code_q  <= cfg_page_code;
          elog_q  <= cfg_ent_log2;
          ind_q   <= cfg_indirect;
          entry_q <= '0;
          hit_q   <= 1'b0;
          if (cfg_indirect && cfg_page_code == PG_CODE_RSVD) st_q <= ST_DONE;
          else if (cfg_indirect)                             st_q <= ST_L1_REQ;
          else                                               st_q <= ST_ENT_REQ;
        end
        ST_L1_REQ:  if (mem_req_ready) st_q <= ST_L1_WAIT;
        ST_L1_WAIT: if (mem_rsp_valid) begin
          desc_q <= mem_rsp_data;
          st_q   <= mem_rsp_data[DESC_VALID] ? ST_ENT_REQ : ST_DONE;
        end
        ST_ENT_REQ: if (mem_req_ready) st_q <= ST_ENT_WAIT;
        ST_ENT_WAIT: if (mem_rsp_valid) begin
          entry_q <= mem_rsp_data;
          hit_q   <= mem_rsp_data[0];
          st_q    <= ST_DONE;
        end
        ST_DONE: if (res_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (st_q == ST_IDLE);
  assign mem_req_valid = (st_q == ST_L1_REQ) || (st_q == ST_ENT_REQ);
  assign mem_req_addr  = (st_q == ST_L1_REQ) ? l1_addr : (ind_q ? l2_addr : flat_addr);
  assign res_valid     = (st_q == ST_DONE);
  assign res_entry     = entry_q;
  assign res_hit       = hit_q;

  AST_SINGLE_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready); // R8

  AST_MEMREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R9

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_entry) && $stable(res_hit)); // R10

  AST_BAD_DESC_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_L1_WAIT) && mem_rsp_valid && !mem_rsp_data[DESC_VALID]
      |=> res_valid && !res_hit && !mem_req_valid); // R4

  AST_RSVD_CODE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && cfg_indirect && (cfg_page_code == PG_CODE_RSVD)
      |=> res_valid && !res_hit && !mem_req_valid); // R7

  AST_HIT_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_hit |-> res_entry[0]); // R6

endmodule

// File: rtl/tel_locator.sv
module tel_locator #(
  parameter int ADDR_W         = 52,
  parameter int ID_W           = 20,
  parameter int DEV_ENTRY_LOG2 = 3,
  parameter int COL_ENTRY_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ID_W-1:0]   req_id,
  input  logic              req_table,
  input  logic [ADDR_W-1:0] dev_base,
  input  logic              dev_indirect,
  input  logic [1:0]        dev_page_code,
  input  logic [ADDR_W-1:0] col_base,
  input  logic              col_indirect,
  input  logic [1:0]        col_page_code,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [63:0]       res_entry,
  output logic              res_hit
);

  localparam logic [2:0] DEV_ELOG = 3'(DEV_ENTRY_LOG2);
  localparam logic [2:0] COL_ELOG = 3'(COL_ENTRY_LOG2);

  logic [ADDR_W-1:0] sel_base;
  logic              sel_ind;
  logic [1:0]        sel_code;
  logic [2:0]        sel_elog;

  always_comb begin
    if (req_table) begin
      sel_base = col_base;
      sel_ind  = col_indirect;
      sel_code = col_page_code;
      sel_elog = COL_ELOG;
    end else begin
      sel_base = dev_base;
      sel_ind  = dev_indirect;
      sel_code = dev_page_code;
      sel_elog = DEV_ELOG;
    end
  end

  logic [ID_W-1:0]   id_q;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        code_q;
  logic [2:0]        elog_q;
  logic [63:0]       desc_q;
  logic [ADDR_W-1:0] flat_addr;
  logic [ADDR_W-1:0] l1_addr;
  logic [ADDR_W-1:0] l2_addr;

  tel_addr_gen #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_addr (
    .id        (id_q),
    .base      (base_q),
    .pg_code   (code_q),
    .ent_log2  (elog_q),
    .l1_desc   (desc_q),
    .flat_addr (flat_addr),
    .l1_addr   (l1_addr),
    .l2_addr   (l2_addr)
  );

  tel_walker #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_walk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_id        (req_id),
    .cfg_base      (sel_base),
    .cfg_indirect  (sel_ind),
    .cfg_page_code (sel_code),
    .cfg_ent_log2  (sel_elog),
    .id_q          (id_q),
    .base_q        (base_q),
    .code_q        (code_q),
    .elog_q        (elog_q),
    .desc_q        (desc_q),
    .flat_addr     (flat_addr),
    .l1_addr       (l1_addr),
    .l2_addr       (l2_addr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .res_valid     (res_valid),
    .res_ready     (res_ready),
    .res_entry     (res_entry),
    .res_hit       (res_hit)
  );

endmodule

// File: tb/tel_locator_bench.sv
`timescale 1ns/1ps
module tel_locator_bench;

  localparam int ADDR_W = 52;
  localparam int ID_W   = 20;
  localparam logic [63:0] DEV_ESZ = 64'd8;
  localparam logic [63:0] COL_ESZ = 64'd16;
  localparam logic [63:0] V63     = 64'h8000_0000_0000_0000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ID_W-1:0]   req_id = '0;
  logic              req_table = 1'b0;
  logic [ADDR_W-1:0] dev_base = '0;
  logic              dev_indirect = 1'b0;
  logic [1:0]        dev_page_code = '0;
  logic [ADDR_W-1:0] col_base = '0;
  logic              col_indirect = 1'b0;
  logic [1:0]        col_page_code = '0;
  logic              mem_req_valid;
  logic              mem_req_ready = 1'b0;
  logic [ADDR_W-1:0] mem_req_addr;
  logic              mem_rsp_valid = 1'b0;
  logic [63:0]       mem_rsp_data = '0;
  logic              res_valid;
  logic              res_ready = 1'b1;
  logic [63:0]       res_entry;
  logic              res_hit;

  tel_locator u_tel_locator (.*);

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  logic [63:0] mem [logic [ADDR_W-1:0]];
  int          reads = 0;
  logic [ADDR_W-1:0] rd_addr [0:3];
  bit          pend = 1'b0;
  logic [ADDR_W-1:0] pend_addr = '0;
  int          ncyc = 0;

  logic [63:0] got_entry;
  logic        got_hit;

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired: actual=hung expected=complete");
      finish_run();
    end
  end

  // memory model: one response one cycle after each handshake, rhythmic stall
  always @(negedge clk) begin
    ncyc++;
    mem_rsp_valid = 1'b0;
    if (pend) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = mem.exists(pend_addr) ? mem[pend_addr] : 64'd0;
      pend          = 1'b0;
      mem_req_ready = 1'b0;
    end else begin
      mem_req_ready = (ncyc % 4) != 1;
      if (mem_req_valid && mem_req_ready) begin
        pend      = 1'b1;
        pend_addr = mem_req_addr;
        if (reads < 4) rd_addr[reads] = mem_req_addr;
        reads++;
      end
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] pg_bytes(input int code);
    return 64'd4096 << (2 * code);
  endfunction

  function automatic logic [63:0] exp_l1(input logic [63:0] base, input int code, input logic [63:0] id);
    return base + (id / (pg_bytes(code) / 64'd8)) * 64'd8;
  endfunction

  function automatic logic [63:0] exp_l2(input logic [63:0] desc, input int code,
                                         input logic [63:0] id, input logic [63:0] esz);
    logic [63:0] m;
    m = (64'd1 << (51 - code)) - 64'd1;
    return ((desc >> code) & m) + (id % (pg_bytes(code) / esz)) * esz;
  endfunction

  task automatic lookup(input bit tbl, input int id);
    int w;
    reads = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_table = tbl;
    req_id    = ID_W'(id);
    @(negedge clk);
    req_valid = 1'b0;
    w = 0;
    while (!res_valid && w < 200) begin
      @(negedge clk);
      w++;
    end
    got_entry = res_entry;
    got_hit   = res_hit;
    if (res_ready) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 req_ready", 64'(req_ready), 64'd1);
    check("R1 mem_req_valid", 64'(mem_req_valid), 64'd0);
    check("R1 res_valid", 64'(res_valid), 64'd0);
  endtask

  task automatic t_flat_dev();
    dev_base = 52'h1000; dev_indirect = 1'b0;
    mem[52'h1000 + 5 * 8] = 64'h0000_ABCD_0000_0001;
    lookup(1'b0, 5);
    check("R2 reads", 64'(reads), 64'd1);
    check("R2 addr", 64'(rd_addr[0]), 64'h1000 + 64'd5 * DEV_ESZ);
    check("R6 entry", got_entry, 64'h0000_ABCD_0000_0001);
    check("R6 hit", 64'(got_hit), 64'd1);
  endtask

  task automatic t_flat_col();
    col_base = 52'h8000; col_indirect = 1'b0;
    mem[52'h8000 + 3 * 16] = 64'h1234_5678_9ABC_DEF0;
    lookup(1'b1, 3);
    check("R2 col addr", 64'(rd_addr[0]), 64'h8000 + 64'd3 * COL_ESZ);
    check("R6 even entry", got_entry, 64'h1234_5678_9ABC_DEF0);
    check("R6 even miss", 64'(got_hit), 64'd0);
  endtask

  task automatic t_ind(input bit tbl, input int code, input int id,
                       input logic [63:0] l2b, input logic [63:0] junk, input string tag);
    logic [63:0] base, desc, a1, a2, esz, ent;
    base = 64'h20_0000;
    esz  = tbl ? COL_ESZ : DEV_ESZ;
    if (tbl) begin col_base = ADDR_W'(base); col_indirect = 1'b1; col_page_code = 2'(code); end
    else     begin dev_base = ADDR_W'(base); dev_indirect = 1'b1; dev_page_code = 2'(code); end
    desc = V63 | (l2b << code) | junk;
    a1   = exp_l1(base, code, 64'(id));
    a2   = exp_l2(desc, code, 64'(id), esz);
    ent  = 64'hFEED_0000_0000_0011 + 64'(code);
    mem[ADDR_W'(a1)] = desc;
    mem[ADDR_W'(a2)] = ent;
    lookup(tbl, id);
    check({"R3 l1 addr ", tag}, 64'(rd_addr[0]), a1);
    check({"R5 l2 addr ", tag}, 64'(rd_addr[1]), a2);
    check({"R5 reads ", tag}, 64'(reads), 64'd2);
    check({"R6 entry ", tag}, got_entry, ent);
    check({"R6 hit ", tag}, 64'(got_hit), 64'(ent[0]));
  endtask

  task automatic t_bad_desc();
    dev_base = 52'h30_0000; dev_indirect = 1'b1; dev_page_code = 2'd0;
    mem[52'h30_0000] = 64'h7FFF_FFFF_FFFF_FFFF;
    lookup(1'b0, 7);
    check("R4 reads", 64'(reads), 64'd1);
    check("R4 hit", 64'(got_hit), 64'd0);
    check("R4 entry", got_entry, 64'd0);
  endtask

  task automatic t_rsvd_code();
    col_indirect = 1'b1; col_page_code = 2'd3;
    lookup(1'b1, 9);
    check("R7 reads", 64'(reads), 64'd0);
    check("R7 hit", 64'(got_hit), 64'd0);
    check("R7 entry", got_entry, 64'd0);
  endtask

  task automatic t_result_hold();
    logic [63:0] held;
    dev_indirect = 1'b0; dev_base = 52'h1000;
    res_ready = 1'b0;
    lookup(1'b0, 5);
    held = got_entry;
    repeat (4) @(negedge clk);
    check("R10 valid held", 64'(res_valid), 64'd1);
    check("R10 entry held", res_entry, held);
    check("R8 no accept", 64'(req_ready), 64'd0);
    res_ready = 1'b1;
    @(negedge clk);
    check("R10 released", 64'(res_valid), 64'd0);
    check("R8 ready again", 64'(req_ready), 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_flat_dev();
    t_flat_col();
    t_ind(1'b0, 0, 1000,  64'h2_0000,   64'd0,                  "code0");
    t_ind(1'b1, 1, 5000,  64'h4_0000,   64'd0,                  "code1");
    t_ind(1'b0, 2, 70000, 64'h10_0000,  64'h1000_0000_0000_0000, "code2");
    t_bad_desc();
    t_rsvd_code();
    t_result_hold();
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule